// File: doc/BRIEF.md
# System-Management RAM Window Control

This block holds the one-byte control register that governs access to the protected system-management memory window. Software writes the register through a byte-wide configuration write at a fixed configuration offset. The block then decides, for each memory access presented to it, whether the access is served by DRAM or forwarded to the PCI bus. Each access carries a flag saying whether the processor is in system-management mode and a flag saying whether the access is an instruction fetch or a data reference.

The register has four meaningful bits: a window enable, a sticky lock, a "closed" bit that hides the window from data references, and an "open" bit that exposes the window outside system-management mode. The open bit is meant for firmware setting the window up. Once the lock is set, the open bit is forced low and can no longer be changed. The lock itself can only be cleared by a power-on reset. Setting open and closed together while unlocked is illegal. The block reports this on an error flag and sends accesses to PCI while it lasts.

Top module: `smram_gate`

## Requirements
- R1: After power-on reset (`por_n` low) the register reads 0x02, `route_valid` is 0, `route_dram` is 0 and `cfg_err` is 0.
- R2: A write (`cfg_wr`=1) with `cfg_addr` equal to 0x72 stores `(cfg_wdata & 0x78) | 0x02` one clock later when the lock was clear. Bit positions: 6 = open, 5 = closed, 4 = lock, 3 = enable. Bits 7, 2 and 0 always read 0 and bit 1 always reads 1.
- R3: A cycle without `cfg_wr`, or a write to any other offset, leaves the register unchanged.
- R4: If the stored lock bit is 1 before a matching write, the new value has open forced to 0 and lock forced to 1. Only `por_n` clears the lock.
- R5: `acc_req` in one cycle gives `route_valid`=1 in the next cycle. `route_dram` (1 = DRAM, 0 = PCI) is decided from the register value held before that clock edge. A write in the same cycle does not affect that access. Without a request, `route_valid` and `route_dram` are 0.
- R6: With enable 0, every access goes to PCI.
- R7: With enable 1, lock 0, open 1 and closed 0, every access goes to DRAM, whatever the mode and type.
- R8: With enable 1, lock 0, open 1 and closed 1, `cfg_err` is 1 and every access goes to PCI. In all other register states `cfg_err` is 0.
- R9: With enable 1, system-management mode asserted, and either lock 1 or open 0: closed 1 sends code to DRAM and data to PCI; closed 0 sends both to DRAM.
- R10: With enable 1, system-management mode deasserted, and either lock 1 or open 0, every access goes to PCI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset of the write |
| cfg_wdata | input | 8 | Configuration write data |
| acc_req | input | 1 | Memory access request into the window |
| acc_smm | input | 1 | Request made in system-management mode |
| acc_is_code | input | 1 | 1 = instruction fetch, 0 = data reference |
| smram_ctl | output | 8 | Stored control register value |
| route_valid | output | 1 | Routing decision valid for last cycle's request |
| route_dram | output | 1 | 1 = DRAM, 0 = PCI |
| cfg_err | output | 1 | Illegal open-and-closed combination stored |

## Verification
The assertions assume that `acc_smm` and `acc_is_code` are only meaningful while `acc_req` is high. They also assume that `por_n` is asserted before any checked behaviour, so that the lock starts clear. The stimulus drives all inputs on the falling edge, so every request and write is settled well before the rising edge. It pulses `por_n` between random epochs so that the lock is set and cleared many times. Lock-bit writes are kept rare, so that the unlocked states, the illegal state among them, get most of the random traffic.

// File: rtl/smram_pkg.sv
package smram_pkg;

  localparam int CTL_W = 8;

  typedef struct packed {
    logic       rsvd7;
    logic       open_b;
    logic       closed_b;
    logic       lock_b;
    logic       enable_b;
    logic [2:0] seg;
  } smram_ctl_t;

  localparam logic [CTL_W-1:0] CTL_RESET   = 8'h02;
  localparam logic [CTL_W-1:0] CTL_KEEP    = 8'h78;
  localparam logic [CTL_W-1:0] CTL_FIXED   = 8'h02;

  // New stored value for a matching write, given the value held before it.
  function automatic smram_ctl_t ctl_next(input smram_ctl_t prev,
                                          input logic [CTL_W-1:0] wdata);
    smram_ctl_t n;
    n = smram_ctl_t'((wdata & CTL_KEEP) | CTL_FIXED);
    if (prev.lock_b) begin
      n.open_b = 1'b0;
      n.lock_b = 1'b1;
    end
    return n;
  endfunction

  // Open and closed together while unlocked and enabled.
  function automatic logic ctl_illegal(input smram_ctl_t c);
    return c.enable_b & ~c.lock_b & c.open_b & c.closed_b;
  endfunction

  // 1 = DRAM, 0 = PCI.
  function automatic logic route_to_dram(input smram_ctl_t c,
                                         input logic smm,
                                         input logic is_code);
    logic r;
    if (!c.enable_b)                      r = 1'b0;
    else if (!c.lock_b && c.open_b)       r = ~c.closed_b;
    else if (!smm)                        r = 1'b0;
    else                                  r = is_code | ~c.closed_b;
    return r;
  endfunction

endpackage

// File: rtl/smram_ctl_reg.sv
module smram_ctl_reg
  import smram_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  CFG_OFFSET = 8'h72
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CTL_W-1:0]  cfg_wdata,
  output smram_ctl_t        ctl_q,
  output logic              ctl_bad
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CFG_OFFSET);

  logic       wr_hit;
  smram_ctl_t ctl_d;

  assign wr_hit  = cfg_wr && (cfg_addr == HIT_ADDR);
  assign ctl_d   = wr_hit ? ctl_next(ctl_q, cfg_wdata) : ctl_q;
  assign ctl_bad = ctl_illegal(ctl_q);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) ctl_q <= smram_ctl_t'(CTL_RESET);
    else        ctl_q <= ctl_d;
  end

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!por_n)
    (ctl_q.seg == 3'b010) && !ctl_q.rsvd7);                       // R2

  AST_HOLD_NO_HIT: assert property (@(posedge clk) disable iff (!por_n)
    !wr_hit |=> $stable(ctl_q));                                  // R3

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    ctl_q.lock_b |=> ctl_q.lock_b);                               // R4

  AST_LOCK_CLOSES_OPEN: assert property (@(posedge clk) disable iff (!por_n)
    (wr_hit && ctl_q.lock_b) |=> !ctl_q.open_b);                  // R4

endmodule

// File: rtl/smram_route.sv
module smram_route
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  smram_ctl_t ctl,
  input  logic       ctl_bad,
  input  logic       acc_req,
  input  logic       acc_smm,
  input  logic       acc_is_code,
  output logic       route_valid,
  output logic       route_dram
);

  logic dram_d;

  assign dram_d = acc_req && !ctl_bad && route_to_dram(ctl, acc_smm, acc_is_code);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      route_valid <= 1'b0;
      route_dram  <= 1'b0;
    end else begin
      route_valid <= acc_req;
      route_dram  <= dram_d;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    !acc_req |=> !route_valid && !route_dram);                     // R5

  AST_DISABLED_PCI: assert property (@(posedge clk) disable iff (!por_n)
    (acc_req && !ctl.enable_b) |=> route_valid && !route_dram);    // R6

  AST_ILLEGAL_PCI: assert property (@(posedge clk) disable iff (!por_n)
    (acc_req && ctl_bad) |=> !route_dram);                         // R8

  AST_SMM_DATA_CLOSED: assert property (@(posedge clk) disable iff (!por_n)
    (acc_req && ctl.enable_b && ctl.closed_b && !acc_is_code)
      |=> !route_dram);                                            // R9

  AST_NON_SMM_LOCKED: assert property (@(posedge clk) disable iff (!por_n)
    (acc_req && !acc_smm && ctl.lock_b) |=> !route_dram);          // R10

endmodule

// File: rtl/smram_gate.sv
module smram_gate
  import smram_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] CFG_OFFSET = 8'h72
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              acc_req,
  input  logic              acc_smm,
  input  logic              acc_is_code,
  output logic [7:0]        smram_ctl,
  output logic              route_valid,
  output logic              route_dram,
  output logic              cfg_err
);

  smram_ctl_t ctl_q;
  logic       ctl_bad;

  smram_ctl_reg #(.ADDR_W(ADDR_W), .CFG_OFFSET(CFG_OFFSET)) u_reg (
    .clk       (clk),
    .por_n     (por_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ctl_q     (ctl_q),
    .ctl_bad   (ctl_bad)
  );

  smram_route u_route (
    .clk         (clk),
    .por_n       (por_n),
    .ctl         (ctl_q),
    .ctl_bad     (ctl_bad),
    .acc_req     (acc_req),
    .acc_smm     (acc_smm),
    .acc_is_code (acc_is_code),
    .route_valid (route_valid),
    .route_dram  (route_dram)
  );

  assign smram_ctl = ctl_q;
  assign cfg_err   = ctl_bad;

  AST_ERR_MEANS_OPEN_CLOSED: assert property (@(posedge clk) disable iff (!por_n)
    cfg_err |-> (smram_ctl[6] && smram_ctl[5] && smram_ctl[3])); // R8

endmodule

// File: tb/smram_gate_bench.sv
module smram_gate_bench;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic [7:0] cfg_wdata = 8'h00;
  logic       acc_req = 1'b0;
  logic       acc_smm = 1'b0;
  logic       acc_is_code = 1'b0;
  logic [7:0] smram_ctl;
  logic       route_valid, route_dram, cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] model = 8'h02;

  always #10ns clk = ~clk;

  smram_gate u_smram_gate (
    .clk(clk), .por_n(por_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_req(acc_req), .acc_smm(acc_smm),
    .acc_is_code(acc_is_code), .smram_ctl(smram_ctl),
    .route_valid(route_valid), .route_dram(route_dram), .cfg_err(cfg_err)
  );

  // Bench restatement of the routing table.
  function automatic bit exp_dram(logic [7:0] c, bit smm, bit code);
    bit en = c[3], lk = c[4], cl = c[5], op = c[6];
    if (!en) return 0;
    if (!lk && op && cl) return 0;
    if (!lk && op) return 1;
    if (!smm) return 0;
    if (cl) return code;
    return 1;
  endfunction

  function automatic bit exp_err(logic [7:0] c);
    return (c[6:3] == 4'b1101);
  endfunction

  function automatic logic [7:0] exp_store(logic [7:0] old, logic [7:0] w);
    logic [7:0] n = {1'b0, w[6:3], 3'b010};
    if (old[4]) n = {1'b0, 1'b0, n[5], 1'b1, n[3:0]};
    return n;
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(bit wr, logic [7:0] a, logic [7:0] w,
                      bit req, bit smm, bit code, string req_tag);
    bit erv, erd;
    cfg_wr = wr; cfg_addr = a; cfg_wdata = w;
    acc_req = req; acc_smm = smm; acc_is_code = code;
    erv = req;
    erd = req ? exp_dram(model, smm, code) : 1'b0;
    if (wr && a == 8'h72) model = exp_store(model, w);
    @(posedge clk); @(negedge clk);
    chk(wr ? "R2" : "R3", "ctl", smram_ctl, model);
    chk("R5", "route_valid", {7'd0, route_valid}, {7'd0, erv});
    chk(req_tag, "route_dram", {7'd0, route_dram}, {7'd0, erd});
    chk("R8", "cfg_err", {7'd0, cfg_err}, {7'd0, exp_err(model)});
    cfg_wr = 0; acc_req = 0;
  endtask

  task automatic power_on();
    por_n = 0;
    repeat (2) @(negedge clk);
    por_n = 1;
    model = 8'h02;
    @(negedge clk);
    chk("R1", "ctl after reset", smram_ctl, 8'h02);
    chk("R1", "route_valid after reset", {7'd0, route_valid}, 8'h00);
    chk("R1", "cfg_err after reset", {7'd0, cfg_err}, 8'h00);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    @(negedge clk);
    power_on();
    // Directed corners
    step(1, 8'h72, 8'hFF, 0, 0, 0, "R2");          // 0x7A: locked, open+closed ignored
    chk("R2", "all-ones write", smram_ctl, 8'h7A);
    step(0, 8'h00, 8'h00, 1, 0, 1, "R10");         // locked, non-SMM -> PCI
    step(0, 8'h00, 8'h00, 1, 1, 0, "R9");          // locked SMM closed data -> PCI
    step(0, 8'h00, 8'h00, 1, 1, 1, "R9");          // locked SMM closed code -> DRAM
    step(1, 8'h72, 8'h48, 0, 0, 0, "R4");          // lock forces open 0
    chk("R4", "open forced low", smram_ctl, 8'h1A);
    power_on();                                    // R4 lock cleared only by reset
    step(1, 8'h72, 8'h68, 0, 0, 0, "R8");          // open+closed+enable
    chk("R8", "illegal stored", smram_ctl, 8'h6A);
    step(0, 8'h00, 8'h00, 1, 1, 1, "R8");          // illegal -> PCI
    step(1, 8'h72, 8'h48, 1, 0, 0, "R5");          // access uses old (illegal) value
    step(0, 8'h00, 8'h00, 1, 0, 0, "R7");          // open -> DRAM non-SMM data
    step(1, 8'h73, 8'h00, 1, 1, 1, "R3");          // other offset ignored
    step(1, 8'h72, 8'h28, 1, 0, 1, "R7");
    step(0, 8'h00, 8'h00, 1, 1, 0, "R9");          // closed SMM data -> PCI
    step(0, 8'h00, 8'h00, 1, 1, 1, "R9");
    step(0, 8'h00, 8'h00, 1, 0, 1, "R10");
    step(1, 8'h72, 8'h20, 1, 1, 0, "R9");
    step(0, 8'h00, 8'h00, 1, 1, 1, "R6");          // disabled -> PCI
    // Constrained random epochs
    for (int e = 0; e < 12; e++) begin
      power_on();
      for (int i = 0; i < 400; i++) begin
        logic [7:0] w = 8'($urandom);
        logic [7:0] a = ($urandom % 8 == 0) ? 8'($urandom) : 8'h72;
        bit wr = ($urandom % 3 == 0);
        if ($urandom % 16 != 0) w[4] = 1'b0;
        step(wr, a, w, $urandom % 4 != 0, 1'($urandom), 1'($urandom),
             model[3] ? (model[4] ? "R10" : "R9") : "R6");
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule